// File: doc/BRIEF.md
# Embedded Controller Link Slave Sequencer

This block sits behind the byte engine of an I2C slave port that talks to an embedded controller. The controller is always the bus master. For each byte it moves, the byte engine presents one event strobe with a set of flags (interrupt, start/address phase, read direction, end of transfer) and the byte it received. The sequencer turns these events into whole messages. A write from the controller is collected into a receive buffer and length-checked when the transfer ends. A write of the read command followed by a repeated-start read makes the sequencer supply the bytes of the head message from the host's transmit queue.

The host cannot start a transfer on its own. It asks for one with an active-low request line, and the controller answers by reading. When nothing is queued at the moment the read begins, a fixed three-byte no-op message is sent in its place. When the controller ends a read early, the same message is offered again from its first byte. Accepted receive messages are reported with their length. The buffer can be read through a random-access port until the next message from the controller starts.

Top module: `ec_link_fsm`

## Requirements
- R1: An event with interrupt and start set and read clear opens a transfer and moves to the command phase. One cycle later `addr_err_o` pulses if the byte differs from `own_addr_i`, and stays low if it matches.
- R2: In the command phase, an event with only the interrupt flag set stores its byte at receive index 0.
- R3: After the command byte, an event with interrupt, start and read set is accepted only if byte 0 is 0x01. Acceptance loads transmit byte 0 onto `tx_data_o`. Otherwise the sequencer goes idle and the fill byte 0xFF is loaded.
- R4: In the transmit phase, each read event (read set, start and end clear) loads the next byte. A read made after all `tx_len_i` bytes have been sent loads 0xFF and returns the sequencer to idle.
- R5: If `tx_avail_i` is low when a read is accepted, the bytes 0x02, 0x07, 0x02 are sent in place of a queued message, and no `tx_done_o` follows.
- R6: `req_n_o` is low while `tx_avail_i` is high and the sequencer is not transmitting, and goes high the cycle after the first byte of an accepted read is loaded. An end event in the transmit phase pulses `tx_done_o` if every byte of a queued message was sent. If the end comes early, `req_n_o` goes low again and the next accepted read restarts at byte 0.
- R7: At an end event in the receive phase, the expected length is set by byte 0 and byte 1. If bit 7 of byte 0 is clear, or bits 6:5 are 2'b10, it is byte 1 plus 2. Bits 6:5 of 2'b00 mean 2 and 2'b01 mean 3. 2'b11 matches no length. A match pulses `rx_valid_o` with `rx_len_o`; a mismatch pulses `rx_drop_o`.
- R8: `xfer_done_o` pulses together with `rx_valid_o` only when bit 7 of byte 0 is clear.
- R9: In the receive or transmit phase, a flag combination that does not fit the phase returns the sequencer to idle. Later data and end events are then ignored until the next start.
- R10: Receive bytes past `RX_DEPTH` (default 32) are discarded and the stored count saturates at `RX_DEPTH`.
- R11: An event with the interrupt flag clear changes nothing.
- R12: `tx_load_o` pulses, one cycle after the event, only for events with interrupt and read set and end clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 8 | Expected address byte |
| ev_valid_i | input | 1 | One-cycle byte event strobe |
| ev_irq_i | input | 1 | Interrupt flag of the event |
| ev_start_i | input | 1 | Start/address flag of the event |
| ev_rnw_i | input | 1 | Read-direction flag of the event |
| ev_end_i | input | 1 | End-of-transfer flag of the event |
| ev_byte_i | input | 8 | Byte received with the event |
| tx_avail_i | input | 1 | Transmit queue holds a message |
| tx_len_i | input | TX_LW | Byte count of the head message |
| tx_idx_o | output | TX_LW | Index of the head-message byte wanted |
| tx_byte_i | input | 8 | Head-message byte at `tx_idx_o` (combinational) |
| tx_load_o | output | 1 | Load `tx_data_o` into the byte engine |
| tx_data_o | output | 8 | Byte to send |
| tx_done_o | output | 1 | Head message fully sent, pop it |
| req_n_o | output | 1 | Service request line, active low |
| rx_valid_o | output | 1 | Receive message accepted |
| rx_drop_o | output | 1 | Receive message discarded on length |
| rx_len_o | output | RX_PW | Length of the accepted message |
| rx_idx_i | input | RX_IW | Receive buffer read index |
| rx_data_o | output | 8 | Receive buffer byte at `rx_idx_i` |
| xfer_done_o | output | 1 | Response to an outstanding request received |
| addr_err_o | output | 1 | Address byte mismatch |

## Verification
The assertions assume that `ev_valid_i` lasts one cycle per byte and that the flags carry meaning only while it is high. They also assume the transmit queue stays stable while the sequencer is transmitting and is popped only in response to `tx_done_o`. The stimulus sends each event as a single strobe with idle cycles between events. It changes `tx_avail_i` only between transfers, and takes the head message away only after the done pulse has been seen. All the illegal flag combinations used are still well-formed single events.

// File: rtl/ec_link_pkg.sv
package ec_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_FIRST,
    ST_TX,
    ST_RX
  } link_st_e;

  localparam logic [7:0] READ_CMD = 8'h01;
  localparam int unsigned NOOP_LEN = 3;

  // no-op filler: 02 07 02
  function automatic logic [7:0] noop_byte(input logic [1:0] idx);
    return (idx == 2'd1) ? 8'h07 : 8'h02;
  endfunction

  function automatic logic [8:0] rx_expect(input logic [7:0] b0, input logic [7:0] b1);
    logic [8:0] n;
    if (!b0[7] || b0[6:5] == 2'b10) n = {1'b0, b1} + 9'd2;
    else if (b0[6:5] == 2'b00)      n = 9'd2;
    else if (b0[6:5] == 2'b01)      n = 9'd3;
    else                            n = 9'd0;
    return n;
  endfunction

endpackage

// File: rtl/ec_rx_buf.sv
module ec_rx_buf #(
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wa_i,
  input  logic [7:0]    wd_i,
  input  logic [IW-1:0] ra_i,
  output logic [7:0]    rd_o,
  output logic [7:0]    b0_o,
  output logic [7:0]    b1_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd_o = mem_q[ra_i];
  assign b0_o = mem_q[0];
  assign b1_o = mem_q[1];

endmodule

// File: rtl/ec_tx_src.sv
module ec_tx_src #(
  parameter int LW = 8
) (
  input  logic          use_noop_i,
  input  logic [1:0]    noop_idx_i,
  input  logic [7:0]    q_byte_i,
  input  logic [LW-1:0] q_len_i,
  output logic [7:0]    byte_o,
  output logic [LW-1:0] len_o
);
  import ec_link_pkg::*;

  assign byte_o = use_noop_i ? noop_byte(noop_idx_i) : q_byte_i;
  assign len_o  = use_noop_i ? LW'(NOOP_LEN) : q_len_i;

endmodule

// File: rtl/ec_link_fsm.sv
module ec_link_fsm #(
  parameter int         RX_DEPTH  = 32,
  parameter int         TX_LW     = 8,
  parameter logic [7:0] FILL_BYTE = 8'hFF,
  localparam int        RX_IW     = $clog2(RX_DEPTH),
  localparam int        RX_PW     = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       own_addr_i,
  input  logic             ev_valid_i,
  input  logic             ev_irq_i,
  input  logic             ev_start_i,
  input  logic             ev_rnw_i,
  input  logic             ev_end_i,
  input  logic [7:0]       ev_byte_i,
  input  logic             tx_avail_i,
  input  logic [TX_LW-1:0] tx_len_i,
  output logic [TX_LW-1:0] tx_idx_o,
  input  logic [7:0]       tx_byte_i,
  output logic             tx_load_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_done_o,
  output logic             req_n_o,
  output logic             rx_valid_o,
  output logic             rx_drop_o,
  output logic [RX_PW-1:0] rx_len_o,
  input  logic [RX_IW-1:0] rx_idx_i,
  output logic [7:0]       rx_data_o,
  output logic             xfer_done_o,
  output logic             addr_err_o
);
  import ec_link_pkg::*;

  localparam int CW = (RX_PW > 9) ? RX_PW : 9;

  link_st_e         st_q, st_d;
  logic [TX_LW-1:0] pos_q, pos_d;
  logic [RX_PW-1:0] rxn_q, rxn_d, len_q, len_d;
  logic             noop_q, noop_d;
  logic             load_q, load_d, done_q, done_d;
  logic             valid_q, valid_d, drop_q, drop_d;
  logic             xdone_q, xdone_d, aerr_q, aerr_d, req_n_q, req_n_d;
  logic [7:0]       data_q, data_d;

  logic             wr_en;
  logic [RX_IW-1:0] wr_idx;
  logic [7:0]       b0, b1;
  logic             src_noop;
  logic [7:0]       src_byte;
  logic [TX_LW-1:0] src_len;
  logic [2:0]       flg;

  assign tx_idx_o = (st_q == ST_TX) ? pos_q : '0;
  assign src_noop = (st_q == ST_TX) ? noop_q : !tx_avail_i;

  ec_rx_buf #(.DEPTH(RX_DEPTH), .IW(RX_IW)) rx_buf_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_en),
    .wa_i  (wr_idx),
    .wd_i  (ev_byte_i),
    .ra_i  (rx_idx_i),
    .rd_o  (rx_data_o),
    .b0_o  (b0),
    .b1_o  (b1)
  );

  ec_tx_src #(.LW(TX_LW)) tx_src_i (
    .use_noop_i(src_noop),
    .noop_idx_i(tx_idx_o[1:0]),
    .q_byte_i  (tx_byte_i),
    .q_len_i   (tx_len_i),
    .byte_o    (src_byte),
    .len_o     (src_len)
  );

  // {end, start, rnw}; irq is implied inside the event branch
  assign flg = {ev_end_i, ev_start_i, ev_rnw_i};

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    rxn_d   = rxn_q;
    len_d   = len_q;
    noop_d  = noop_q;
    load_d  = 1'b0;
    data_d  = FILL_BYTE;
    done_d  = 1'b0;
    valid_d = 1'b0;
    drop_d  = 1'b0;
    xdone_d = 1'b0;
    aerr_d  = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = '0;
    if (ev_valid_i && ev_irq_i) begin
      load_d = ev_rnw_i && !ev_end_i;
      if (ev_start_i && !ev_rnw_i) begin
        st_d   = ST_CMD;
        aerr_d = (ev_byte_i != own_addr_i);
      end else begin
        case (st_q)
          ST_IDLE: ;
          ST_CMD: begin
            if (flg == 3'b000) begin
              wr_en  = 1'b1;
              wr_idx = '0;
              rxn_d  = RX_PW'(1);
              st_d   = ST_FIRST;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_FIRST: begin
            if (flg == 3'b011) begin
              if (b0 == READ_CMD) begin
                st_d   = ST_TX;
                noop_d = !tx_avail_i;
                data_d = src_byte;
                pos_d  = TX_LW'(1);
              end else begin
                st_d = ST_IDLE;
              end
            end else if (flg == 3'b000) begin
              wr_en  = 1'b1;
              wr_idx = RX_IW'(1);
              rxn_d  = RX_PW'(2);
              st_d   = ST_RX;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_TX: begin
            if (ev_end_i) begin
              st_d  = ST_IDLE;
              pos_d = '0;
              if (pos_q == src_len && !noop_q) done_d = 1'b1;
            end else if (!ev_rnw_i || ev_start_i) begin
              st_d = ST_IDLE;
            end else if (pos_q < src_len) begin
              data_d = src_byte;
              pos_d  = pos_q + 1'b1;
            end else begin
              st_d = ST_IDLE;  // read past the end
            end
          end
          ST_RX: begin
            if (ev_end_i && !ev_rnw_i) begin
              st_d = ST_IDLE;
              if (CW'(rxn_q) == CW'(rx_expect(b0, b1))) begin
                valid_d = 1'b1;
                len_d   = rxn_q;
                xdone_d = !b0[7];
              end else begin
                drop_d = 1'b1;
              end
            end else if (ev_rnw_i || ev_start_i) begin
              st_d = ST_IDLE;
            end else if (rxn_q < RX_PW'(RX_DEPTH)) begin
              wr_en  = 1'b1;
              wr_idx = rxn_q[RX_IW-1:0];
              rxn_d  = rxn_q + 1'b1;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
    req_n_d = !(tx_avail_i && st_d != ST_TX && !done_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pos_q   <= '0;
      rxn_q   <= '0;
      len_q   <= '0;
      noop_q  <= 1'b0;
      load_q  <= 1'b0;
      data_q  <= FILL_BYTE;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      drop_q  <= 1'b0;
      xdone_q <= 1'b0;
      aerr_q  <= 1'b0;
      req_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      rxn_q   <= rxn_d;
      len_q   <= len_d;
      noop_q  <= noop_d;
      load_q  <= load_d;
      data_q  <= data_d;
      done_q  <= done_d;
      valid_q <= valid_d;
      drop_q  <= drop_d;
      xdone_q <= xdone_d;
      aerr_q  <= aerr_d;
      req_n_q <= req_n_d;
    end
  end

  assign tx_load_o   = load_q;
  assign tx_data_o   = data_q;
  assign tx_done_o   = done_q;
  assign req_n_o     = req_n_q;
  assign rx_valid_o  = valid_q;
  assign rx_drop_o   = drop_q;
  assign rx_len_o    = len_q;
  assign xfer_done_o = xdone_q;
  assign addr_err_o  = aerr_q;

endmodule

// File: rtl/ec_link_chk.sv
module ec_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ev_valid_i,
  input logic ev_irq_i,
  input logic ev_start_i,
  input logic ev_rnw_i,
  input logic ev_end_i,
  input logic tx_load_o,
  input logic tx_done_o,
  input logic req_n_o,
  input logic rx_valid_o,
  input logic rx_drop_o,
  input logic xfer_done_o,
  input logic addr_err_o
);

  // R12
  load_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> $past(ev_valid_i && ev_irq_i && ev_rnw_i && !ev_end_i));

  // R1
  addr_err_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> $past(ev_valid_i && ev_irq_i && ev_start_i && !ev_rnw_i));

  // R7
  rx_verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rx_drop_o));

  // R7
  rx_verdict_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o || rx_drop_o) |-> $past(ev_valid_i && ev_irq_i && ev_end_i));

  // R8
  xfer_done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> rx_valid_o);

  // R6
  done_releases_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> req_n_o);

endmodule

bind ec_link_fsm ec_link_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_valid_i (ev_valid_i),
  .ev_irq_i   (ev_irq_i),
  .ev_start_i (ev_start_i),
  .ev_rnw_i   (ev_rnw_i),
  .ev_end_i   (ev_end_i),
  .tx_load_o  (tx_load_o),
  .tx_done_o  (tx_done_o),
  .req_n_o    (req_n_o),
  .rx_valid_o (rx_valid_o),
  .rx_drop_o  (rx_drop_o),
  .xfer_done_o(xfer_done_o),
  .addr_err_o (addr_err_o)
);

// File: tb/ec_link_fsm_tb_top.sv
`timescale 1ns/1ps
module ec_link_fsm_tb_top;

  localparam int RX_DEPTH = 32;
  localparam int TX_LW    = 8;
  localparam int RX_IW    = $clog2(RX_DEPTH);
  localparam int RX_PW    = $clog2(RX_DEPTH + 1);

  // flag codes {end, start, rnw, irq}
  localparam logic [3:0] F_I   = 4'b0001;
  localparam logic [3:0] F_R   = 4'b0011;
  localparam logic [3:0] F_S   = 4'b0101;
  localparam logic [3:0] F_SR  = 4'b0111;
  localparam logic [3:0] F_E   = 4'b1001;
  localparam logic [3:0] F_ER  = 4'b1011;
  localparam logic [7:0] OWN   = 8'h8A;

  // {avail, flags[4], byte[8], exp_load, exp_data[8], exp_done}
  localparam logic [22:0] VEC [14] = '{
    {1'b1, F_S,  8'h8A, 1'b0, 8'hFF, 1'b0},
    {1'b1, F_I,  8'h01, 1'b0, 8'hFF, 1'b0},
    {1'b1, F_SR, 8'h8B, 1'b1, 8'h03, 1'b0},
    {1'b1, F_R,  8'h00, 1'b1, 8'hAA, 1'b0},
    {1'b1, F_R,  8'h00, 1'b1, 8'hBB, 1'b0},
    {1'b1, F_R,  8'h00, 1'b1, 8'hCC, 1'b0},
    {1'b1, F_ER, 8'h00, 1'b0, 8'hFF, 1'b1},
    {1'b0, F_S,  8'h8A, 1'b0, 8'hFF, 1'b0},
    {1'b0, F_I,  8'h01, 1'b0, 8'hFF, 1'b0},
    {1'b0, F_SR, 8'h8B, 1'b1, 8'h02, 1'b0},
    {1'b0, F_R,  8'h00, 1'b1, 8'h07, 1'b0},
    {1'b0, F_R,  8'h00, 1'b1, 8'h02, 1'b0},
    {1'b0, F_R,  8'h00, 1'b1, 8'hFF, 1'b0},
    {1'b0, F_R,  8'h00, 1'b1, 8'hFF, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ev_valid = 1'b0, ev_irq = 1'b0, ev_start = 1'b0, ev_rnw = 1'b0, ev_end = 1'b0;
  logic [7:0]       ev_byte = '0;
  logic             tx_avail = 1'b0;
  logic [TX_LW-1:0] tx_idx;
  logic [7:0]       tx_byte;
  logic             tx_load, tx_done, req_n, rx_valid, rx_drop, xfer_done, addr_err;
  logic [7:0]       tx_data, rx_data;
  logic [RX_PW-1:0] rx_len;
  logic [RX_IW-1:0] rx_idx = '0;
  logic [7:0]       q_mem [4] = '{8'h03, 8'hAA, 8'hBB, 8'hCC};

  int n_chk = 0, n_bad = 0;
  logic c_load, c_done, c_valid, c_drop, c_xd, c_aerr, c_req;
  logic [7:0] c_data;
  logic [RX_PW-1:0] c_len;

  always #10 clk = ~clk;

  assign tx_byte = q_mem[tx_idx[1:0]];

  ec_link_fsm #(.RX_DEPTH(RX_DEPTH), .TX_LW(TX_LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN),
    .ev_valid_i(ev_valid), .ev_irq_i(ev_irq), .ev_start_i(ev_start),
    .ev_rnw_i(ev_rnw), .ev_end_i(ev_end), .ev_byte_i(ev_byte),
    .tx_avail_i(tx_avail), .tx_len_i(TX_LW'(4)), .tx_idx_o(tx_idx),
    .tx_byte_i(tx_byte), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .tx_done_o(tx_done), .req_n_o(req_n), .rx_valid_o(rx_valid),
    .rx_drop_o(rx_drop), .rx_len_o(rx_len), .rx_idx_i(rx_idx),
    .rx_data_o(rx_data), .xfer_done_o(xfer_done), .addr_err_o(addr_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic [3:0] f, input logic [7:0] b);
    @(negedge clk);
    {ev_end, ev_start, ev_rnw, ev_irq} = f;
    ev_byte  = b;
    ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    c_load = tx_load;  c_data = tx_data;  c_done = tx_done;
    c_valid = rx_valid; c_drop = rx_drop; c_len = rx_len;
    c_xd = xfer_done;  c_aerr = addr_err; c_req = req_n;
  endtask

  task automatic rd_rx(input int idx, input logic [7:0] exp, input string tag);
    rx_idx = RX_IW'(idx);
    #1;
    check(tag, rx_data, exp);
  endtask

  task automatic open_wr(input logic [7:0] b0, input logic [7:0] b1);
    ev(F_S, OWN);
    ev(F_I, b0);
    ev(F_I, b1);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset req_n", req_n, 1);
    check("R12 reset load", tx_load, 0);
    check("R7 reset valid", rx_valid, 0);
    rst_n = 1'b1;
    tx_avail = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 req low on pending msg", req_n, 0);

    // table: queued read, then no-op read with underflow
    for (int i = 0; i < 14; i++) begin
      logic [22:0] v;
      v = VEC[i];
      tx_avail = v[22];
      ev(v[21:18], v[17:10]);
      check((i >= 9) ? "R5 tx data" : "R4 tx data", c_data, v[8:1]);
      check("R12 tx load", c_load, v[9]);
      check("R6 tx done", c_done, v[0]);
      if (i == 1) check("R6 req low before read", c_req, 0);
      if (i == 2) check("R3 accept, R6 req released", c_req, 1);
      if (i == 6) check("R6 req high at done", c_req, 1);
      if (i == 0) check("R1 own addr no error", c_aerr, 0);
    end

    // R1 mismatch
    ev(F_S, 8'h50);
    check("R1 addr mismatch", c_aerr, 1);

    // R3 read without read command
    tx_avail = 1'b1;
    open_wr(8'h05, 8'h00);
    ev(F_S, OWN); ev(F_I, 8'h05); ev(F_SR, 8'h8B);
    check("R3 reject load", c_load, 1);
    check("R3 reject data", c_data, 8'hFF);
    check("R3 reject req stays low", c_req, 0);
    ev(F_R, 8'h00);
    check("R3 idle after reject", c_data, 8'hFF);

    // R6 premature end and resend
    ev(F_S, OWN); ev(F_I, 8'h01); ev(F_SR, 8'h8B);
    check("R6 first byte", c_data, 8'h03);
    ev(F_R, 8'h00);
    check("R4 second byte", c_data, 8'hAA);
    ev(F_ER, 8'h00);
    check("R6 premature no done", c_done, 0);
    check("R6 premature req low", c_req, 0);
    ev(F_S, OWN); ev(F_I, 8'h01); ev(F_SR, 8'h8B);
    check("R6 resend from byte0", c_data, 8'h03);
    ev(F_R, 0); ev(F_R, 0); ev(F_R, 0);
    check("R4 last byte", c_data, 8'hCC);
    ev(F_ER, 8'h00);
    check("R6 done after full send", c_done, 1);
    tx_avail = 1'b0;

    // R7/R8 variable length response
    open_wr(8'h02, 8'h03);
    check("R12 no load on write", c_load, 0);
    ev(F_I, 8'h11); ev(F_I, 8'h22); ev(F_I, 8'h33);
    ev(F_E, 8'h00);
    check("R7 var valid", c_valid, 1);
    check("R7 var len", c_len, 5);
    check("R8 response done", c_xd, 1);
    check("R7 var no drop", c_drop, 0);
    rd_rx(0, 8'h02, "R2 byte0 stored");
    rd_rx(1, 8'h03, "R7 byte1");
    rd_rx(4, 8'h33, "R7 last payload");

    // R7 short message
    open_wr(8'h02, 8'h03);
    ev(F_I, 8'h11);
    ev(F_E, 8'h00);
    check("R7 short drop", c_drop, 1);
    check("R7 short not valid", c_valid, 0);

    // R7 fixed 2-byte event
    open_wr(8'h80, 8'h44);
    ev(F_E, 8'h00);
    check("R7 fixed2 valid", c_valid, 1);
    check("R7 fixed2 len", c_len, 2);
    check("R8 event no done", c_xd, 0);

    // R7 fixed 3-byte event
    open_wr(8'hA0, 8'h01);
    ev(F_I, 8'h02);
    ev(F_E, 8'h00);
    check("R7 fixed3 valid", c_valid, 1);
    check("R7 fixed3 len", c_len, 3);

    // R7 variable event
    open_wr(8'hC0, 8'h01);
    ev(F_I, 8'h55);
    ev(F_E, 8'h00);
    check("R7 var event len", c_len, 3);
    check("R8 var event no done", c_xd, 0);

    // R7 reserved size code
    open_wr(8'hE0, 8'h00);
    ev(F_E, 8'h00);
    check("R7 code 11 drop", c_drop, 1);

    // R9 unexpected read during receive
    open_wr(8'h02, 8'h01);
    ev(F_R, 8'h00);
    ev(F_I, 8'h77);
    ev(F_E, 8'h00);
    check("R9 abort no valid", c_valid, 0);
    check("R9 abort no drop", c_drop, 0);

    // R11 event without irq
    open_wr(8'h02, 8'h02);
    ev(4'b0000, 8'h99);
    ev(F_I, 8'h11); ev(F_I, 8'h22);
    ev(F_E, 8'h00);
    check("R11 no-irq ignored valid", c_valid, 1);
    check("R11 no-irq ignored len", c_len, 4);
    rd_rx(2, 8'h11, "R11 byte2 not overwritten");

    // R10 overflow
    open_wr(8'h02, 8'h1E);
    for (int k = 1; k <= 35; k++) ev(F_I, 8'(k));
    ev(F_E, 8'h00);
    check("R10 saturated valid", c_valid, 1);
    check("R10 saturated len", c_len, 32);
    rd_rx(31, 8'h1E, "R10 last stored byte");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule